// File: doc/BRIEF.md
# Accumulator Minicomputer Core

A 16-bit processor built around one accumulator, with a 12-bit program counter and a 12-bit memory address register, sequenced by a multi-cycle state machine. It fetches instruction words from an external synchronous memory. Read data arrives on the clock edge after the read enable. It executes memory-reference instructions with optional indirection and an operate group. The operate group covers shifts, rotates, skips, negate, clear, halt, interrupt mask control and direct I/O.

In an instruction word, bit 15 is the indirect flag, bits 14:12 the opcode and bits 11:0 the address. Opcode 7 selects the operate group. Its sub-operation sits in bits 11:8. For I/O the device number is in bits 7:4 and the function in bits 3:0. For shifts and bit tests a count or bit index is in bits 3:0. A single maskable interrupt level saves PC, AC and the overflow flag into shadow registers and vectors to a fixed address. A halt stops the core until a run or single-step pulse arrives.

Top module: `accumCpu`

## Requirements
- R1: While reset is held and in the first cycle after release, the core is not halted, holds both I/O strobes low, holds the write enable low, and drives a read at address RESET_PC (default 0). Interrupts start masked.
- R2: The memory-reference opcodes in bits 14:12 are: 0 loads AC from M[A]; 2 adds M[A] to AC and sets overflow to the signed two's complement overflow; 4 ANDs M[A] into AC; 5 stores AC to M[A]. Overflow keeps its value until the next add, increment-and-skip, clear or interrupt return.
- R3: With bit 15 set, A is replaced by bits 11:0 of M[A]. The replacement repeats while bit 15 of the fetched pointer word is set.
- R4: Opcode 1 jumps to A. Opcode 3 writes the return address (its own address + 1) to M[A], continues at A+1 and clears AC without touching overflow.
- R5: Opcode 6 writes M[A]+1 back to M[A] and loads it into AC. It skips the next instruction when the result is zero.
- R6: Operate sub-op 0 moves AC left by bits 3:0. With bit 15 clear it shifts zeros in; with bit 15 set it rotates, so the MSB feeds the LSB.
- R7: Skip sub-ops: 4 skips if AC is zero, 5 if AC is non-zero, 6 if overflow is clear. Sub-op 7 tests AC bit (15 - bits 3:0), so index 0 is the MSB. It skips when that bit equals instruction bit 15.
- R8: Sub-op 1 clears AC and overflow; sub-op 2 replaces AC with its two's complement negation.
- R9: Sub-op D presents AC on ioOutData and pulses ioOutStrobe for one cycle. Sub-op E pulses ioInStrobe for one cycle and loads ioInData into AC at the end of that cycle. In both, ioDev and ioFunc carry instruction bits 7:4 and 3:0. The two strobes are never high together.
- R10: An interrupt request sets a pending latch. While the interrupt is masked (sub-op 8 masks, sub-op A unmasks), the latch waits. Otherwise it is taken before the next fetch: PC, AC and overflow are saved, the interrupt is masked, and execution continues at IRQ_VEC (default 12'h002). Sub-op B restores PC, AC and overflow and unmasks.
- R11: Sub-op 9 halts the core. While halted it issues no memory access and stays halted until runPulse resumes free running, or stepPulse executes exactly one instruction and halts again.
- R12: A memory read and a memory write never occur in the same cycle, and a write enable never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 12 | Memory address for read or write |
| memRdEn | output | 1 | Read request; data expected next cycle |
| memRdData | input | 16 | Read data, registered by the memory |
| memWrEn | output | 1 | Write request |
| memWrData | output | 16 | Write data |
| ioDev | output | 4 | Device number of the current I/O instruction |
| ioFunc | output | 4 | Function code of the current I/O instruction |
| ioOutStrobe | output | 1 | Output transfer pulse |
| ioInStrobe | output | 1 | Input transfer pulse |
| ioOutData | output | 16 | Accumulator value for output transfers |
| ioInData | input | 16 | Data returned by the selected device |
| irqReq | input | 1 | Interrupt request |
| runPulse | input | 1 | Leave halt and run freely |
| stepPulse | input | 1 | Leave halt for one instruction |
| halted | output | 1 | Core is halted |

## Verification
The assertions watch properties that hold in every cycle: the reset fetch address, exclusion between read and write and between the two I/O strobes, single-cycle writes and strobes, and a halted core that stays idle without a resume pulse. Arithmetic results, overflow, indirection chains, the skip conditions, subroutine linkage, interrupt save and restore, and single stepping only show up as values that programs leave in memory or push through the output port, so the bench scenarios cover those.

// File: rtl/cpuPkg.sv
package cpuPkg;
  localparam int DW = 16;
  localparam int AW = 12;

  typedef enum logic [2:0] {
    OP_LDA = 3'd0, OP_JMP = 3'd1, OP_ADD = 3'd2, OP_JSR = 3'd3,
    OP_AND = 3'd4, OP_STA = 3'd5, OP_IAS = 3'd6, OP_OPR = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    SUB_SHIFT = 4'h0, SUB_CLR = 4'h1, SUB_NEG = 4'h2, SUB_SKZ = 4'h4,
    SUB_SKNZ = 4'h5, SUB_SKNOV = 4'h6, SUB_SKBIT = 4'h7, SUB_MASK = 4'h8,
    SUB_HALT = 4'h9, SUB_UNMASK = 4'hA, SUB_IRET = 4'hB, SUB_OUT = 4'hD,
    SUB_IN = 4'hE
  } subop_e;

  typedef enum logic [3:0] {
    AC_HOLD, AC_LOAD, AC_ADD, AC_AND, AC_INC, AC_CLR, AC_ZERO,
    AC_NEG, AC_SHL, AC_ROL, AC_IN, AC_RESTORE
  } acop_e;

  typedef enum logic [1:0] {WR_AC, WR_PC, WR_INC} wrsel_e;

  typedef struct packed {
    logic   irLoad;
    logic   maFromRd;
    logic   pcInc;
    logic   pcFromMa;
    logic   pcFromMaNext;
    logic   pcVector;
    logic   pcRestore;
    logic   saveShadow;
    logic   addrFromPc;
    acop_e  acOp;
    wrsel_e wrSel;
  } ctl_t;
endpackage

// File: rtl/cpuDatapath.sv
module cpuDatapath import cpuPkg::*; #(
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] IRQ_VEC  = 12'h002
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic [DW-1:0] memRdData,
  input  logic [DW-1:0] ioInData,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  output logic [DW-1:0] acOut,
  output logic          acZero,
  output logic          ovfOut,
  output logic          acBit
);
  logic [AW-1:0] pc, ma, shPc;
  logic [DW-1:0] ac, shAc;
  logic          ovf, shOvf;

  logic [DW-1:0] sum, incVal, shl, rol;
  logic          addOvf, incOvf;
  logic [3:0]    sh, bitIdx;

  assign sh     = ir[3:0];
  assign bitIdx = 4'(DW - 1) - ir[3:0];
  assign sum    = ac + memRdData;
  assign incVal = memRdData + 1'b1;
  assign addOvf = (ac[DW-1] == memRdData[DW-1]) && (sum[DW-1] != ac[DW-1]);
  assign incOvf = (memRdData == {1'b0, {(DW-1){1'b1}}});
  assign shl    = ac << sh;
  assign rol    = (ac << sh) | (ac >> (DW - int'(sh)));

  assign memAddr = ctl.addrFromPc ? pc : ma;
  assign acOut   = ac;
  assign acZero  = (ac == '0);
  assign ovfOut  = ovf;
  assign acBit   = ac[bitIdx];

  always_comb begin
    case (ctl.wrSel)
      WR_PC:   memWrData = {{(DW-AW){1'b0}}, pc};
      WR_INC:  memWrData = incVal;
      default: memWrData = ac;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC; ma <= '0; ac <= '0; ovf <= 1'b0; ir <= '0;
      shPc <= '0; shAc <= '0; shOvf <= 1'b0;
    end else begin
      if (ctl.irLoad)   ir <= memRdData;
      if (ctl.maFromRd) ma <= memRdData[AW-1:0];
      if (ctl.saveShadow) begin
        shPc <= pc; shAc <= ac; shOvf <= ovf;
      end
      if (ctl.pcVector)          pc <= IRQ_VEC;
      else if (ctl.pcRestore)    pc <= shPc;
      else if (ctl.pcFromMa)     pc <= ma;
      else if (ctl.pcFromMaNext) pc <= ma + 1'b1;
      else if (ctl.pcInc)        pc <= pc + 1'b1;
      case (ctl.acOp)
        AC_LOAD:    ac <= memRdData;
        AC_ADD:     begin ac <= sum; ovf <= addOvf; end
        AC_AND:     ac <= ac & memRdData;
        AC_INC:     begin ac <= incVal; ovf <= incOvf; end
        AC_CLR:     begin ac <= '0; ovf <= 1'b0; end
        AC_ZERO:    ac <= '0;
        AC_NEG:     ac <= -ac;
        AC_SHL:     ac <= shl;
        AC_ROL:     ac <= rol;
        AC_IN:      ac <= ioInData;
        AC_RESTORE: begin ac <= shAc; ovf <= shOvf; end
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/cpuCtrl.sv
module cpuCtrl import cpuPkg::*; (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] memRdData,
  input  logic [7:0]    irHi,
  input  logic          acZero,
  input  logic          ovf,
  input  logic          acBit,
  input  logic          irqReq,
  input  logic          runPulse,
  input  logic          stepPulse,
  output ctl_t          ctl,
  output logic          memRdEn,
  output logic          memWrEn,
  output logic          ioOutStrobe,
  output logic          ioInStrobe,
  output logic          halted
);
  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_IND1, S_IND2, S_MEM1, S_MEM2, S_OPR, S_HALT
  } state_e;

  state_e state, nextState;
  logic   masked, pending, stepMode;
  logic   irqTake, instrDone, setMask, clrMask;
  opcode_e op;

  assign op      = opcode_e'(irHi[6:4]);
  assign irqTake = (state == S_FETCH) && pending && !masked;
  assign halted  = (state == S_HALT);

  always_comb begin
    ctl = '0;
    memRdEn = 1'b0; memWrEn = 1'b0;
    ioOutStrobe = 1'b0; ioInStrobe = 1'b0;
    nextState = state; instrDone = 1'b0;
    setMask = 1'b0; clrMask = 1'b0;
    case (state)
      S_FETCH: begin
        if (irqTake) begin
          ctl.saveShadow = 1'b1; ctl.pcVector = 1'b1;
        end else begin
          ctl.addrFromPc = 1'b1; memRdEn = 1'b1; nextState = S_DECODE;
        end
      end
      S_DECODE: begin
        ctl.irLoad = 1'b1; ctl.maFromRd = 1'b1; ctl.pcInc = 1'b1;
        if (memRdData[14:12] == OP_OPR) nextState = S_OPR;
        else if (memRdData[15])         nextState = S_IND1;
        else                            nextState = S_MEM1;
      end
      S_IND1: begin
        memRdEn = 1'b1; nextState = S_IND2;
      end
      S_IND2: begin
        ctl.maFromRd = 1'b1;
        nextState = memRdData[15] ? S_IND1 : S_MEM1;
      end
      S_MEM1: begin
        case (op)
          OP_JMP: begin ctl.pcFromMa = 1'b1; instrDone = 1'b1; end
          OP_STA: begin memWrEn = 1'b1; ctl.wrSel = WR_AC; instrDone = 1'b1; end
          OP_JSR: begin
            memWrEn = 1'b1; ctl.wrSel = WR_PC; ctl.pcFromMaNext = 1'b1;
            ctl.acOp = AC_ZERO; instrDone = 1'b1;
          end
          default: begin memRdEn = 1'b1; nextState = S_MEM2; end
        endcase
      end
      S_MEM2: begin
        instrDone = 1'b1;
        case (op)
          OP_LDA: ctl.acOp = AC_LOAD;
          OP_ADD: ctl.acOp = AC_ADD;
          OP_AND: ctl.acOp = AC_AND;
          OP_IAS: begin
            ctl.acOp = AC_INC; memWrEn = 1'b1; ctl.wrSel = WR_INC;
            ctl.pcInc = &memRdData;
          end
          default: ;
        endcase
      end
      S_OPR: begin
        instrDone = 1'b1;
        case (subop_e'(irHi[3:0]))
          SUB_SHIFT:  ctl.acOp = irHi[7] ? AC_ROL : AC_SHL;
          SUB_CLR:    ctl.acOp = AC_CLR;
          SUB_NEG:    ctl.acOp = AC_NEG;
          SUB_SKZ:    ctl.pcInc = acZero;
          SUB_SKNZ:   ctl.pcInc = !acZero;
          SUB_SKNOV:  ctl.pcInc = !ovf;
          SUB_SKBIT:  ctl.pcInc = (acBit == irHi[7]);
          SUB_MASK:   setMask = 1'b1;
          SUB_UNMASK: clrMask = 1'b1;
          SUB_IRET: begin
            ctl.acOp = AC_RESTORE; ctl.pcRestore = 1'b1; clrMask = 1'b1;
          end
          SUB_OUT:    ioOutStrobe = 1'b1;
          SUB_IN:     begin ioInStrobe = 1'b1; ctl.acOp = AC_IN; end
          SUB_HALT:   begin instrDone = 1'b0; nextState = S_HALT; end
          default:    ;
        endcase
      end
      S_HALT: begin
        if (runPulse || stepPulse) nextState = S_FETCH;
      end
      default: nextState = S_FETCH;
    endcase
    if (instrDone) nextState = stepMode ? S_HALT : S_FETCH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH; masked <= 1'b1; pending <= 1'b0; stepMode <= 1'b0;
    end else begin
      state <= nextState;
      if (irqTake) pending <= irqReq;
      else         pending <= pending | irqReq;
      if (irqTake || setMask) masked <= 1'b1;
      else if (clrMask)       masked <= 1'b0;
      if (state == S_HALT) begin
        if (runPulse)       stepMode <= 1'b0;
        else if (stepPulse) stepMode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/accumCpu.sv
module accumCpu import cpuPkg::*; #(
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] IRQ_VEC  = 12'h002
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] memAddr,
  output logic          memRdEn,
  input  logic [DW-1:0] memRdData,
  output logic          memWrEn,
  output logic [DW-1:0] memWrData,
  output logic [3:0]    ioDev,
  output logic [3:0]    ioFunc,
  output logic          ioOutStrobe,
  output logic          ioInStrobe,
  output logic [DW-1:0] ioOutData,
  input  logic [DW-1:0] ioInData,
  input  logic          irqReq,
  input  logic          runPulse,
  input  logic          stepPulse,
  output logic          halted
);
  ctl_t          ctl;
  logic [DW-1:0] ir;
  logic          acZero, ovf, acBit;

  assign ioDev  = ir[7:4];
  assign ioFunc = ir[3:0];

  cpuCtrl u_ctrl (
    .clk(clk), .rst(rst), .memRdData(memRdData), .irHi(ir[15:8]),
    .acZero(acZero), .ovf(ovf), .acBit(acBit), .irqReq(irqReq),
    .runPulse(runPulse), .stepPulse(stepPulse), .ctl(ctl),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .ioOutStrobe(ioOutStrobe),
    .ioInStrobe(ioInStrobe), .halted(halted)
  );

  cpuDatapath #(.RESET_PC(RESET_PC), .IRQ_VEC(IRQ_VEC)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdData(memRdData),
    .ioInData(ioInData), .ir(ir), .memAddr(memAddr),
    .memWrData(memWrData), .acOut(ioOutData), .acZero(acZero),
    .ovfOut(ovf), .acBit(acBit)
  );
endmodule

// File: rtl/accumCpuChk.sv
module accumCpuChk #(
  parameter logic [11:0] RESET_PC = '0
) (
  input logic        clk,
  input logic        rst,
  input logic [11:0] memAddr,
  input logic        memRdEn,
  input logic        memWrEn,
  input logic        ioOutStrobe,
  input logic        ioInStrobe,
  input logic        runPulse,
  input logic        stepPulse,
  input logic        halted
);
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (memRdEn && memAddr == RESET_PC && !halted));

  p_rdwr_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(memRdEn && memWrEn));

  p_write_single_r12: assert property (@(posedge clk) disable iff (rst)
    memWrEn |=> !memWrEn);

  p_io_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(ioOutStrobe && ioInStrobe));

  p_out_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ioOutStrobe |=> !ioOutStrobe);

  p_in_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ioInStrobe |=> !ioInStrobe);

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (halted && !runPulse && !stepPulse) |=> halted);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!memRdEn && !memWrEn && !ioOutStrobe && !ioInStrobe));
endmodule

bind accumCpu accumCpuChk #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .memAddr(memAddr), .memRdEn(memRdEn),
  .memWrEn(memWrEn), .ioOutStrobe(ioOutStrobe), .ioInStrobe(ioInStrobe),
  .runPulse(runPulse), .stepPulse(stepPulse), .halted(halted)
);

// File: tb/tb_accumCpu.sv
module tb_accumCpu;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam int WATCHDOG = 100000;

  // add vectors: {a, b, expected sum, expected overflow}
  localparam logic [48:0] ADD_VEC [NVEC] = '{
    {16'h0003, 16'h0004, 16'h0007, 1'b0},
    {16'h7FFF, 16'h0001, 16'h8000, 1'b1},
    {16'h8000, 16'hFFFF, 16'h7FFF, 1'b1},
    {16'hFFFF, 16'h0001, 16'h0000, 1'b0},
    {16'h1234, 16'hEDCC, 16'h0000, 1'b0},
    {16'hC000, 16'hC000, 16'h8000, 1'b0},
    {16'h4000, 16'h4000, 16'h8000, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] memAddr;
  logic memRdEn, memWrEn, ioOutStrobe, ioInStrobe, halted;
  logic [15:0] memRdData, memWrData, ioOutData, ioInData;
  logic [3:0] ioDev, ioFunc;
  logic irqReq = 1'b0, runPulse = 1'b0, stepPulse = 1'b0;

  logic [15:0] mem [256];
  int outCnt [16];
  logic [15:0] outLast [16];
  logic [7:0] inSel;
  logic clearLog = 1'b0;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accumCpu dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .ioDev(ioDev), .ioFunc(ioFunc), .ioOutStrobe(ioOutStrobe),
    .ioInStrobe(ioInStrobe), .ioOutData(ioOutData), .ioInData(ioInData),
    .irqReq(irqReq), .runPulse(runPulse), .stepPulse(stepPulse),
    .halted(halted)
  );

  assign ioInData = {8'hA0, ioDev, ioFunc};

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr[7:0]];
    if (memWrEn) mem[memAddr[7:0]] <= memWrData;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (clearLog) begin
      for (int i = 0; i < 16; i++) begin outCnt[i] <= 0; outLast[i] <= '0; end
      inSel <= '0;
    end else begin
      if (ioOutStrobe) begin
        outCnt[ioDev] <= outCnt[ioDev] + 1;
        outLast[ioDev] <= ioOutData;
      end
      if (ioInStrobe) inSel <= {ioDev, ioFunc};
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h7900;
  endtask

  task automatic startRun();
    rst = 1'b1; clearLog = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; clearLog = 1'b0;
  endtask

  task automatic runUntilHalt(input string req);
    int n = 0;
    while (!halted && n < 2000) begin @(negedge clk); n++; end
    check(halted, req, {15'b0, halted}, 16'h0001);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cycles, WATCHDOG);
    summary();
  end

  initial begin
    // R1 reset state
    clearMem();
    startRun();
    check(memRdEn && memAddr == 12'h000, "R1 fetch at reset pc", {4'b0, memAddr}, 16'h0000);
    check(!halted && !memWrEn, "R1 not halted, no write", {14'b0, halted, memWrEn}, 16'h0000);
    check(!ioOutStrobe && !ioInStrobe, "R1 strobes idle", {14'b0, ioOutStrobe, ioInStrobe}, 16'h0000);

    // R2 table of add vectors
    for (int v = 0; v < NVEC; v++) begin
      clearMem();
      mem[0] = 16'h0040; mem[1] = 16'h2041; mem[2] = 16'h5042;
      mem[3] = 16'h7600; mem[4] = 16'h7DF0; mem[5] = 16'h7D10; mem[6] = 16'h7900;
      mem[8'h40] = ADD_VEC[v][48:33]; mem[8'h41] = ADD_VEC[v][32:17]; mem[8'h42] = 16'h0;
      startRun();
      runUntilHalt("R2 add run");
      check(mem[8'h42] == ADD_VEC[v][16:1], "R2 add stored sum", mem[8'h42], ADD_VEC[v][16:1]);
      check(outLast[1] == ADD_VEC[v][16:1], "R2 add output", outLast[1], ADD_VEC[v][16:1]);
      check(outCnt[15] == int'(ADD_VEC[v][0]), "R2 overflow flag via skip",
            16'(outCnt[15]), {15'b0, ADD_VEC[v][0]});
    end

    // R3 indirection with AND, single and double level
    clearMem();
    mem[0] = 16'h8050; mem[1] = 16'h4051; mem[2] = 16'h7D10;
    mem[3] = 16'h8052; mem[4] = 16'h7D20; mem[5] = 16'h7900;
    mem[8'h50] = 16'h0060; mem[8'h60] = 16'hF0F0; mem[8'h51] = 16'h0FF0;
    mem[8'h52] = 16'h8053; mem[8'h53] = 16'h0061; mem[8'h61] = 16'h1111;
    startRun();
    runUntilHalt("R3 run");
    check(outLast[1] == 16'h00F0, "R3 indirect load then R2 and", outLast[1], 16'h00F0);
    check(outLast[2] == 16'h1111, "R3 two-level indirect", outLast[2], 16'h1111);

    // R4 jump and subroutine linkage
    clearMem();
    mem[0] = 16'h1005; mem[5] = 16'h0040; mem[6] = 16'h3070;
    mem[8'h71] = 16'h7D10; mem[8'h72] = 16'h7900; mem[8'h40] = 16'h1234;
    startRun();
    runUntilHalt("R4 run");
    check(mem[8'h70] == 16'h0007, "R4 return address saved", mem[8'h70], 16'h0007);
    check(outCnt[1] == 1 && outLast[1] == 16'h0000, "R4 AC cleared at A+1", outLast[1], 16'h0000);

    // R5 increment and skip on zero
    clearMem();
    mem[0] = 16'h6080; mem[1] = 16'h1000; mem[2] = 16'h7D10; mem[3] = 16'h7900;
    mem[8'h80] = 16'hFFFD;
    startRun();
    runUntilHalt("R5 run");
    check(mem[8'h80] == 16'h0000, "R5 memory written back", mem[8'h80], 16'h0000);
    check(outCnt[1] == 1 && outLast[1] == 16'h0000, "R5 skip taken, AC result",
          16'(outCnt[1]), 16'h0001);

    // R6 shift and rotate, R8 negate
    clearMem();
    mem[0] = 16'h0040; mem[1] = 16'h7004; mem[2] = 16'h7D10;
    mem[3] = 16'h0040; mem[4] = 16'hF004; mem[5] = 16'h7D20;
    mem[6] = 16'h0041; mem[7] = 16'h7200; mem[8] = 16'h7D30; mem[9] = 16'h7900;
    mem[8'h40] = 16'h8421; mem[8'h41] = 16'h0005;
    startRun();
    runUntilHalt("R6 run");
    check(outLast[1] == 16'h4210, "R6 shift left zero fill", outLast[1], 16'h4210);
    check(outLast[2] == 16'h4218, "R6 rotate left", outLast[2], 16'h4218);
    check(outLast[3] == 16'hFFFB, "R8 negate", outLast[3], 16'hFFFB);

    // R7 skips, R8 clear
    clearMem();
    mem[0] = 16'h0040; mem[1] = 16'hF700; mem[2] = 16'h7D20; mem[3] = 16'hF701;
    mem[4] = 16'h7D30; mem[5] = 16'h770F; mem[6] = 16'h7D40; mem[7] = 16'h7500;
    mem[8] = 16'h7D50; mem[9] = 16'h7400; mem[10] = 16'h7D60; mem[11] = 16'h7100;
    mem[12] = 16'h7400; mem[13] = 16'h7D70; mem[14] = 16'h7900;
    mem[8'h40] = 16'h8421;
    startRun();
    runUntilHalt("R7 run");
    check(outCnt[2] == 0, "R7 bit0 (MSB) set skips", 16'(outCnt[2]), 16'h0000);
    check(outCnt[3] == 1, "R7 bit1 clear no skip", 16'(outCnt[3]), 16'h0001);
    check(outCnt[4] == 1, "R7 skip-if-zero on set LSB no skip", 16'(outCnt[4]), 16'h0001);
    check(outCnt[5] == 0, "R7 nonzero skip", 16'(outCnt[5]), 16'h0000);
    check(outCnt[6] == 1, "R7 zero test on nonzero", 16'(outCnt[6]), 16'h0001);
    check(outCnt[7] == 0, "R8 clear then R7 zero skip", 16'(outCnt[7]), 16'h0000);

    // R9 data input
    clearMem();
    mem[0] = 16'h7E53; mem[1] = 16'h7D10; mem[2] = 16'h7900;
    startRun();
    runUntilHalt("R9 run");
    check(inSel == 8'h53, "R9 input device/function", {8'b0, inSel}, 16'h0053);
    check(outLast[1] == 16'hA053, "R9 input data to AC", outLast[1], 16'hA053);

    // R10 pending while masked, entry, restore
    clearMem();
    mem[0] = 16'h1010; mem[2] = 16'h7DE0; mem[3] = 16'h7100; mem[4] = 16'h7B00;
    mem[8'h10] = 16'h0040; mem[8'h11] = 16'h7A00; mem[8'h12] = 16'h7D10; mem[8'h13] = 16'h7900;
    mem[8'h40] = 16'h1234;
    startRun();
    irqReq = 1'b1; repeat (3) @(negedge clk); irqReq = 1'b0;
    runUntilHalt("R10 run");
    check(outCnt[14] == 1 && outLast[14] == 16'h1234, "R10 handler entered once",
          outLast[14], 16'h1234);
    check(outCnt[1] == 1 && outLast[1] == 16'h1234, "R10 AC restored", outLast[1], 16'h1234);

    // R10 request ignored while never unmasked
    clearMem();
    mem[0] = 16'h0040; mem[1] = 16'h1010; mem[2] = 16'h7DE0;
    mem[8'h10] = 16'h7D10; mem[8'h11] = 16'h7900; mem[8'h40] = 16'h4321;
    startRun();
    irqReq = 1'b1; repeat (4) @(negedge clk); irqReq = 1'b0;
    runUntilHalt("R10 masked run");
    check(outCnt[14] == 0, "R10 masked request not taken", 16'(outCnt[14]), 16'h0000);
    check(outLast[1] == 16'h4321, "R10 main program intact", outLast[1], 16'h4321);

    // R11 halt, single step, run
    clearMem();
    mem[0] = 16'h7900; mem[1] = 16'h0040; mem[2] = 16'h7D10; mem[3] = 16'h7D20; mem[4] = 16'h7900;
    mem[8'h40] = 16'h0BEE;
    startRun();
    runUntilHalt("R11 first halt");
    repeat (5) @(negedge clk);
    check(halted && outCnt[1] == 0, "R11 stays halted", {15'b0, halted}, 16'h0001);
    stepPulse = 1'b1; @(negedge clk); stepPulse = 1'b0;
    repeat (10) @(negedge clk);
    check(halted && outCnt[1] == 0, "R11 one step executes load only", 16'(outCnt[1]), 16'h0000);
    stepPulse = 1'b1; @(negedge clk); stepPulse = 1'b0;
    repeat (10) @(negedge clk);
    check(halted && outCnt[1] == 1 && outCnt[2] == 0, "R11 second step one output",
          16'(outCnt[2]), 16'h0000);
    check(outLast[1] == 16'h0BEE, "R11 stepped output value", outLast[1], 16'h0BEE);
    runPulse = 1'b1; @(negedge clk); runPulse = 1'b0;
    runUntilHalt("R11 run to halt");
    check(outCnt[2] == 1, "R11 run resumes", 16'(outCnt[2]), 16'h0001);

    summary();
  end
endmodule